// File: doc/BRIEF.md
# Digital Potentiometer Wiper Register Controller

This block holds the control state of one 64-position digital potentiometer: a volatile 6-bit wiper register whose value is driven straight out as the tap position, and a bank of four retained data registers that keep wiper settings across a reset. Commands reach it as whole bytes from a serial front end that has already recovered the bytes. They arrive on a valid/ready stream, and read results leave on a second valid/ready stream.

An instruction byte carries a 4-bit opcode in bits 7:4 and a data-register select in bits 3:2. Writes take one more byte, of which only the low 6 bits count. Reads return one byte with the value in its low 6 bits and zeros above. The two transfer instructions and step-mode entry finish with the instruction byte alone. While in step mode, pulses on a step strobe move the wiper up or down by one, with saturation at both ends. Any write or transfer into a data register marks the block busy for a fixed number of cycles, and no new byte is accepted during that time. After reset the block copies data register 0 into the wiper.

The controller is a five-state machine. RECALL is entered at reset and goes to IDLE after one cycle, loading the wiper from data register 0. IDLE decodes an accepted instruction byte and moves to WDATA (write opcodes), RDOUT (read opcodes), STEP (step opcode), or stays in IDLE (transfers and unknown opcodes). WDATA returns to IDLE once the data byte is accepted. RDOUT returns to IDLE when the read byte is taken. STEP returns to IDLE when any byte is accepted.

Top module: `dpot_ctrl`

## Requirements
- R1: While reset is asserted, in_ready, rd_valid and busy are 0. At the first clock edge after reset is released, the wiper takes the contents of data register 0. The data registers are not cleared by reset.
- R2: Instruction 0xA0 (opcode 4'hA), followed by a data byte, loads the wiper with the low 6 bits of that byte at the edge that accepts it. Bits 7:6 of the data byte are ignored.
- R3: Instruction 0x90 (opcode 4'h9) presents {2'b00, wiper} on rd_data with rd_valid high. The byte is held stable until rd_ready is seen high at a clock edge. No input byte is accepted while rd_valid is high.
- R4: Instruction 0xC0 | (n<<2) (opcode 4'hC, select n in bits 3:2), followed by a data byte, stores its low 6 bits in data register n. busy then stays high for exactly BUSY_CYCLES cycles, and in_ready is 0 during that time.
- R5: Instruction 0xB0 | (n<<2) (opcode 4'hB) returns {2'b00, data register n} on the read stream.
- R6: Instruction 0xD0 | (n<<2) (opcode 4'hD) copies data register n into the wiper at the edge that accepts the byte. No data byte follows and busy is not raised.
- R7: Instruction 0xE0 | (n<<2) (opcode 4'hE) copies the wiper into data register n. No data byte follows, and busy is raised for BUSY_CYCLES cycles.
- R8: Instruction 0x20 (opcode 4'h2) enters step mode. In step mode, step_pulse high at an edge moves the wiper up by one if step_up is 1 and down by one if step_up is 0, stopping at 0x3F and 0x00. step_pulse has no effect outside step mode.
- R9: In step mode the next accepted byte ends the mode and is discarded, whatever its value.
- R10: An instruction byte with an opcode other than 2, 9, A, B, C, D or E is accepted and has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte valid |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Command byte accepted when high with in_valid |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| rd_ready | input | 1 | Read byte taken when high with rd_valid |
| step_pulse | input | 1 | One-cycle step strobe |
| step_up | input | 1 | Step direction, 1 = up |
| busy | output | 1 | Data register write in progress |
| wiper_pos | output | 6 | Current wiper tap position |

## Verification
The hardest situation to reach is the saturation edge in step mode. It needs the wiper to be placed on 0x00 or 0x3F first, then step mode entered, then a run of pulses pushing past the limit. Directed sequences do exactly this: the wiper is written one tap short of each end and then given several pulses in the direction of that end. Retention across reset is reached by storing a known value in data register 0, letting busy clear, and pulsing reset. Random command mixes then interleave transfers, writes and step bursts against a bench model.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

    typedef enum logic [3:0] {
        OP_STEP    = 4'h2,
        OP_RD_WCR  = 4'h9,
        OP_WR_WCR  = 4'hA,
        OP_RD_DR   = 4'hB,
        OP_WR_DR   = 4'hC,
        OP_XFR_D2W = 4'hD,
        OP_XFR_W2D = 4'hE
    } dpot_op_e;

    typedef enum logic [2:0] {
        ST_RECALL,
        ST_IDLE,
        ST_WDATA,
        ST_RDOUT,
        ST_STEP
    } dpot_state_e;

endpackage

// File: rtl/dpot_busy.sv
module dpot_busy #(
    parameter int BUSY_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(BUSY_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/dpot_regbank.sv
module dpot_regbank #(
    parameter int WIPER_W = 6,
    parameter int NUM_DR  = 4,
    localparam int SEL_W  = $clog2(NUM_DR)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               recall,
    input  logic               wcr_load,
    input  logic [WIPER_W-1:0] wcr_din,
    input  logic               step_en,
    input  logic               step_up,
    input  logic               dr_we,
    input  logic [SEL_W-1:0]   dr_sel,
    input  logic [WIPER_W-1:0] dr_din,
    output logic [WIPER_W-1:0] dr_rd,
    output logic [WIPER_W-1:0] wcr
);
    localparam logic [WIPER_W-1:0] TOP_TAP = '1;

    logic [WIPER_W-1:0] dr_q [NUM_DR];
    logic [WIPER_W-1:0] wcr_q;
    logic [WIPER_W-1:0] wcr_step;

    // Retained registers: no reset, so contents survive rst_n.
    for (genvar i = 0; i < NUM_DR; i++) begin : g_dr
        always_ff @(posedge clk) begin
            if (dr_we && (dr_sel == SEL_W'(i))) begin
                dr_q[i] <= dr_din;
            end
        end
    end

    assign dr_rd = dr_q[dr_sel];

    always_comb begin
        wcr_step = wcr_q;
        if (step_up) begin
            if (wcr_q != TOP_TAP) wcr_step = wcr_q + 1'b1;
        end else begin
            if (wcr_q != '0) wcr_step = wcr_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcr_q <= '0;
        end else if (recall) begin
            wcr_q <= dr_q[0];
        end else if (wcr_load) begin
            wcr_q <= wcr_din;
        end else if (step_en) begin
            wcr_q <= wcr_step;
        end
    end

    assign wcr = wcr_q;
endmodule

// File: rtl/dpot_fsm.sv
module dpot_fsm
    import dpot_pkg::*;
#(
    parameter int WIPER_W = 6,
    parameter int BYTE_W  = 8,
    parameter int NUM_DR  = 4,
    localparam int SEL_W  = $clog2(NUM_DR),
    localparam int SEL_LSB = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [BYTE_W-1:0]  in_data,
    output logic               in_ready,
    output logic               rd_valid,
    output logic [BYTE_W-1:0]  rd_data,
    input  logic               rd_ready,
    input  logic               step_pulse,
    input  logic               busy,
    input  logic [WIPER_W-1:0] wcr,
    input  logic [WIPER_W-1:0] dr_rd,
    output logic               recall,
    output logic               wcr_load,
    output logic [WIPER_W-1:0] wcr_din,
    output logic               step_en,
    output logic               dr_we,
    output logic [SEL_W-1:0]   dr_sel,
    output logic [WIPER_W-1:0] dr_din,
    output logic               busy_start
);
    dpot_state_e        state_q, state_d;
    dpot_op_e           op_q;
    logic [SEL_W-1:0]   sel_q;
    logic [WIPER_W-1:0] rd_q;
    logic               hs;
    dpot_op_e           op_in;
    logic [SEL_W-1:0]   sel_in;

    assign op_in  = dpot_op_e'(in_data[BYTE_W-1 -: 4]);
    assign sel_in = in_data[SEL_LSB +: SEL_W];
    assign hs     = in_valid && in_ready;

    // State register and captured fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RECALL;
            op_q    <= OP_RD_WCR;
            sel_q   <= '0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && hs) begin
                op_q  <= op_in;
                sel_q <= sel_in;
                if (op_in == OP_RD_WCR) rd_q <= wcr;
                else if (op_in == OP_RD_DR) rd_q <= dr_rd;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RECALL: state_d = ST_IDLE;
            ST_IDLE: begin
                if (hs) begin
                    unique case (op_in)
                        OP_RD_WCR, OP_RD_DR: state_d = ST_RDOUT;
                        OP_WR_WCR, OP_WR_DR: state_d = ST_WDATA;
                        OP_STEP:             state_d = ST_STEP;
                        default:             state_d = ST_IDLE;
                    endcase
                end
            end
            ST_WDATA: if (hs) state_d = ST_IDLE;
            ST_RDOUT: if (rd_ready) state_d = ST_IDLE;
            ST_STEP:  if (hs) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready   = 1'b0;
        rd_valid   = 1'b0;
        recall     = 1'b0;
        wcr_load   = 1'b0;
        wcr_din    = in_data[WIPER_W-1:0];
        step_en    = 1'b0;
        dr_we      = 1'b0;
        dr_sel     = sel_q;
        dr_din     = in_data[WIPER_W-1:0];
        busy_start = 1'b0;
        unique case (state_q)
            ST_RECALL: recall = 1'b1;
            ST_IDLE: begin
                in_ready = !busy;
                dr_sel   = sel_in;
                if (hs) begin
                    if (op_in == OP_XFR_D2W) begin
                        wcr_load = 1'b1;
                        wcr_din  = dr_rd;
                    end else if (op_in == OP_XFR_W2D) begin
                        dr_we      = 1'b1;
                        dr_din     = wcr;
                        busy_start = 1'b1;
                    end
                end
            end
            ST_WDATA: begin
                in_ready = !busy;
                if (hs) begin
                    if (op_q == OP_WR_WCR) begin
                        wcr_load = 1'b1;
                    end else begin
                        dr_we      = 1'b1;
                        busy_start = 1'b1;
                    end
                end
            end
            ST_RDOUT: rd_valid = 1'b1;
            ST_STEP: begin
                in_ready = !busy;
                step_en  = step_pulse && !hs;
            end
            default: ;
        endcase
    end

    assign rd_data = {{(BYTE_W-WIPER_W){1'b0}}, rd_q};
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl #(
    parameter int WIPER_W     = 6,
    parameter int BYTE_W      = 8,
    parameter int NUM_DR      = 4,
    parameter int BUSY_CYCLES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [BYTE_W-1:0]  in_data,
    output logic               in_ready,
    output logic               rd_valid,
    output logic [BYTE_W-1:0]  rd_data,
    input  logic               rd_ready,
    input  logic               step_pulse,
    input  logic               step_up,
    output logic               busy,
    output logic [WIPER_W-1:0] wiper_pos
);
    localparam int SEL_W = $clog2(NUM_DR);

    logic               recall, wcr_load, step_en, dr_we, busy_start;
    logic [WIPER_W-1:0] wcr_din, dr_din, dr_rd, wcr;
    logic [SEL_W-1:0]   dr_sel;

    dpot_fsm #(.WIPER_W(WIPER_W), .BYTE_W(BYTE_W), .NUM_DR(NUM_DR)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
        .step_pulse(step_pulse), .busy(busy), .wcr(wcr), .dr_rd(dr_rd),
        .recall(recall), .wcr_load(wcr_load), .wcr_din(wcr_din),
        .step_en(step_en), .dr_we(dr_we), .dr_sel(dr_sel), .dr_din(dr_din),
        .busy_start(busy_start)
    );

    dpot_regbank #(.WIPER_W(WIPER_W), .NUM_DR(NUM_DR)) u_regs (
        .clk(clk), .rst_n(rst_n), .recall(recall),
        .wcr_load(wcr_load), .wcr_din(wcr_din),
        .step_en(step_en), .step_up(step_up),
        .dr_we(dr_we), .dr_sel(dr_sel), .dr_din(dr_din),
        .dr_rd(dr_rd), .wcr(wcr)
    );

    dpot_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(busy_start), .busy(busy)
    );

    assign wiper_pos = wcr;
endmodule

// File: rtl/dpot_ctrl_chk.sv
module dpot_ctrl_chk #(
    parameter int WIPER_W = 6,
    parameter int BYTE_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               rd_valid,
    input logic [BYTE_W-1:0]  rd_data,
    input logic               rd_ready,
    input logic               busy,
    input logic [WIPER_W-1:0] wiper_pos
);
    logic armed;
    logic hs;

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign hs = in_valid && in_ready;

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready); // R4

    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $rose(busy) |-> $past(hs)); // R7

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R3

    AST_RD_NO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !in_ready); // R3

    AST_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !hs |=>
            ({1'b0, wiper_pos} == {1'b0, $past(wiper_pos)}) ||
            ({1'b0, wiper_pos} == {1'b0, $past(wiper_pos)} + 1'b1) ||
            ({1'b0, wiper_pos} + 1'b1 == {1'b0, $past(wiper_pos)})); // R8

    AST_NO_WRAP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !hs && (&wiper_pos) |=> (wiper_pos != '0)); // R8

    AST_NO_WRAP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !hs && (wiper_pos == '0) |=> !(&wiper_pos)); // R8

    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[BYTE_W-1:WIPER_W] == '0)); // R5
endmodule

bind dpot_ctrl dpot_ctrl_chk #(.WIPER_W(WIPER_W), .BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .busy(busy), .wiper_pos(wiper_pos)
);

// File: tb/tb_dpot_ctrl.sv
module tb_dpot_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY_N     = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       rd_ready = 1'b0;
    logic       step_pulse = 1'b0;
    logic       step_up = 1'b0;
    logic       busy;
    logic [5:0] wiper_pos;

    int checks = 0;
    int fails  = 0;
    logic [5:0] wcr_m;
    logic [5:0] dr_m [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpot_ctrl #(.BUSY_CYCLES(BUSY_N)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_ready(rd_ready), .step_pulse(step_pulse), .step_up(step_up),
        .busy(busy), .wiper_pos(wiper_pos)
    );

    function automatic logic [5:0] step_model(logic [5:0] v, logic up);
        if (up) return (v == 6'h3F) ? v : v + 6'd1;
        return (v == 6'h00) ? v : v - 6'd1;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_byte(logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic busy_len(string req);
        int n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk(req, n, BUSY_N);
    endtask

    task automatic read_op(logic [7:0] op, logic [5:0] exp, string req);
        send_byte(op);
        chk(req, int'(rd_valid), 1);
        chk(req, int'(rd_data), int'({2'b00, exp}));
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
        chk(req, int'(rd_valid), 0);
    endtask

    task automatic wr_wcr(logic [7:0] d);
        send_byte(8'hA0);
        send_byte(d);
        wcr_m = d[5:0];
        chk("R2", int'(wiper_pos), int'(wcr_m));
    endtask

    task automatic wr_dr(int n, logic [7:0] d);
        send_byte(8'hC0 | 8'(n << 2));
        send_byte(d);
        dr_m[n] = d[5:0];
        chk("R4", int'(in_ready), 0);
        busy_len("R4");
    endtask

    task automatic steps(int cnt, logic up);
        for (int i = 0; i < cnt; i++) begin
            step_pulse = 1'b1;
            step_up    = up;
            @(negedge clk);
            step_pulse = 1'b0;
            wcr_m = step_model(wcr_m, up);
            chk("R8", int'(wiper_pos), int'(wcr_m));
        end
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        chk("R1", int'(in_ready), 0);
        chk("R1", int'(rd_valid), 0);
        chk("R1", int'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 4; i++) wr_dr(i, 8'(8'h11 * (i + 1)));
        for (int i = 0; i < 4; i++) read_op(8'hB0 | 8'(i << 2), dr_m[i], "R5");

        wr_wcr(8'hC5);
        read_op(8'h90, wcr_m, "R3");

        // R3 hold while rd_ready low
        send_byte(8'h90);
        repeat (3) @(negedge clk);
        chk("R3", int'(rd_valid), 1);
        chk("R3", int'(in_ready), 0);
        chk("R3", int'(rd_data), int'({2'b00, wcr_m}));
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;

        // R1 retention and recall
        wr_dr(0, 8'h2A);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        wcr_m = dr_m[0];
        chk("R1", int'(wiper_pos), 6'h2A);
        read_op(8'hB8, dr_m[2], "R1");

        // R6 transfer data reg 3 to wiper
        send_byte(8'hDC);
        wcr_m = dr_m[3];
        chk("R6", int'(wiper_pos), int'(wcr_m));
        chk("R6", int'(busy), 0);
        chk("R6", int'(in_ready), 1);

        // R7 transfer wiper to data reg 1
        wr_wcr(8'h17);
        send_byte(8'hE4);
        dr_m[1] = wcr_m;
        chk("R7", int'(busy), 1);
        busy_len("R7");
        read_op(8'hB4, 6'h17, "R7");

        // R8 saturation at top and bottom
        wr_wcr(8'h3E);
        send_byte(8'h20);
        steps(3, 1'b1);
        chk("R8", int'(wiper_pos), 6'h3F);
        send_byte(8'h00);
        wr_wcr(8'h01);
        send_byte(8'h20);
        steps(3, 1'b0);
        chk("R8", int'(wiper_pos), 6'h00);

        // R9 terminating byte discarded even if it looks like a write
        send_byte(8'hC0);
        chk("R9", int'(busy), 0);
        chk("R9", int'(in_ready), 1);
        read_op(8'hB0, dr_m[0], "R9");

        // R8 pulses outside step mode ignored
        steps(0, 1'b1);
        step_pulse = 1'b1; step_up = 1'b1;
        repeat (3) @(negedge clk);
        step_pulse = 1'b0;
        chk("R8", int'(wiper_pos), int'(wcr_m));

        // R10 unknown opcodes
        send_byte(8'h50);
        send_byte(8'hF4);
        send_byte(8'h00);
        chk("R10", int'(wiper_pos), int'(wcr_m));
        chk("R10", int'(busy), 0);
        for (int i = 0; i < 4; i++) read_op(8'hB0 | 8'(i << 2), dr_m[i], "R10");

        // Random mix
        for (int k = 0; k < 200; k++) begin
            int sel = int'($urandom_range(0, 3));
            logic [7:0] d = 8'($urandom);
            case ($urandom_range(0, 6))
                0: wr_wcr(d);
                1: read_op(8'h90, wcr_m, "R3");
                2: read_op(8'hB0 | 8'(sel << 2), dr_m[sel], "R5");
                3: wr_dr(sel, d);
                4: begin
                    send_byte(8'hD0 | 8'(sel << 2));
                    wcr_m = dr_m[sel];
                    chk("R6", int'(wiper_pos), int'(wcr_m));
                end
                5: begin
                    send_byte(8'hE0 | 8'(sel << 2));
                    dr_m[sel] = wcr_m;
                    busy_len("R7");
                end
                default: begin
                    send_byte(8'h20);
                    steps(int'($urandom_range(1, 12)), 1'($urandom));
                    send_byte(d);
                    chk("R9", int'(wiper_pos), int'(wcr_m));
                end
            endcase
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule